// File: doc/BRIEF.md
# Code NCO with Residual Phase Capture

A sample-rate code phase generator for a spread-spectrum receiver channel. A fractional chip-phase accumulator advances by a fixed-point increment on every valid input sample, where the increment is the chip rate divided by the sample rate, scaled by 2^PHASE_W. Each time the accumulator wraps past one whole chip, the block raises a one-cycle chip strobe that steps the spreading-code generator by one chip.

On each strobe the block also reports two values. The first is the phase left in the accumulator right after the wrap, which locates the chip edge within a sample period. The second is the number of samples the finished chip took. When the samples-per-chip ratio ns is not an integer, that count alternates between floor(ns) and floor(ns)+1. A chip-index counter over a code of CODE_LEN chips (1023 by default) raises an epoch strobe together with the chip strobe that closes each full code period.

The increment is taken from the input only at chip boundaries. A loop filter can therefore write it at any time without bending the chip that is in progress.

Top module: `code_nco`

## Requirements
- R1: While rst_ni is low and on the first cycle after its release, chip_stb_o and epoch_stb_o are 0 and residual_o and spc_o read 0.
- R2: The accumulator advances only on cycles with sample_valid_i high, by adding the increment modulo 2^PHASE_W. Without a valid sample no strobe is produced and the phase does not move.
- R3: A valid sample whose addition carries out of PHASE_W bits produces chip_stb_o high for exactly the one cycle that follows that sample. Every wrap gives one strobe.
- R4: With each strobe, residual_o holds the PHASE_W-bit sum left after the wrap. This value is always below the increment that was added.
- R5: With each strobe, spc_o holds the number of valid samples since the previous wrap. The wrapping sample is not counted, because it is the first sample of the next chip. After reset the chip under way counts from 0, so the first report is one lower. The count saturates at 2^CNT_W-1. With an increment of exactly 2^(PHASE_W-2), every report after the first is 4.
- R6: The increment is captured from phase_inc_i only on the first valid sample after reset and on each wrapping sample. A change at any other time takes effect only after the next wrap.
- R7: The epoch strobe is high on the cycle of every CODE_LEN-th chip strobe after reset and is never high without a chip strobe.
- R8: Between strobes, residual_o and spc_o hold their last reported values.
- R9: With the increment held constant over a chip, and starting from the previous residual r, the reported count is floor(ns)+1 when r + floor(ns)*inc < 2^PHASE_W, and floor(ns) otherwise. Here floor(ns) is the integer quotient 2^PHASE_W / inc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | A new sample is present this cycle |
| phase_inc_i | input | PHASE_W | Chip-phase increment per sample, fraction of a chip scaled by 2^PHASE_W |
| chip_stb_o | output | 1 | One-cycle strobe per accumulator wrap; steps the code generator |
| residual_o | output | PHASE_W | Phase left after the last wrap |
| spc_o | output | CNT_W | Sample count of the chip that just finished |
| epoch_stb_o | output | 1 | Strobe on the last chip of each code period |

## Verification
The bench aims at the increment change in the middle of a chip. A design that loads the new word at once would shift the wrap and report a wrong sample count for that chip.

It runs non-integer ratios and checks each count against the threshold rule. An off-by-one in counting the wrapping sample would show as every count being one too high or too low.

Gaps in sample_valid_i check that nothing advances or strobes without a sample. A long run against a free-running model counts the epoch strobes, which catches a chip index that wraps at CODE_LEN or CODE_LEN-2.

// File: rtl/code_nco_pkg.sv
package code_nco_pkg;
  localparam int unsigned DEF_PHASE_W  = 32;
  localparam int unsigned DEF_CODE_LEN = 1023;
  localparam int unsigned DEF_CNT_W    = 16;

  typedef struct packed {
    logic stb;
    logic epoch;
  } chip_evt_t;
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned PHASE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [PHASE_W-1:0] inc_i,
  output logic               wrap_o,
  output logic [PHASE_W-1:0] resid_o,
  output logic [PHASE_W-1:0] inc_used_o
);
  logic [PHASE_W-1:0] acc_q, inc_q;
  logic               load_q;
  logic [PHASE_W:0]   sum;

  // first sample after reset uses the live input word
  assign inc_used_o = load_q ? inc_i : inc_q;
  assign sum        = {1'b0, acc_q} + {1'b0, inc_used_o};
  assign wrap_o     = valid_i & sum[PHASE_W];
  assign resid_o    = sum[PHASE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      inc_q  <= '0;
      load_q <= 1'b1;
    end else if (valid_i) begin
      acc_q  <= sum[PHASE_W-1:0];
      load_q <= 1'b0;
      if (sum[PHASE_W] || load_q) inc_q <= inc_i;
    end
  end
endmodule

// File: rtl/chip_sample_counter.sv
module chip_sample_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             wrap_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  // wrapping sample opens the next chip, so it is not part of this count
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (wrap_i)         cnt_q <= CNT_ONE;
    else if (valid_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
  end
endmodule

// File: rtl/chip_index_counter.sv
module chip_index_counter #(
  parameter int unsigned CODE_LEN = 1023
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  output logic last_o
);
  localparam int unsigned IDX_W = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CODE_LEN - 1);

  logic [IDX_W-1:0] idx_q;

  assign last_o = wrap_i && (idx_q == IDX_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (last_o) idx_q <= '0;
    else if (wrap_i) idx_q <= idx_q + 1'b1;
  end
endmodule

// File: rtl/code_nco.sv
module code_nco
  import code_nco_pkg::*;
#(
  parameter int unsigned PHASE_W  = DEF_PHASE_W,
  parameter int unsigned CODE_LEN = DEF_CODE_LEN,
  parameter int unsigned CNT_W    = DEF_CNT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_valid_i,
  input  logic [PHASE_W-1:0] phase_inc_i,
  output logic               chip_stb_o,
  output logic [PHASE_W-1:0] residual_o,
  output logic [CNT_W-1:0]   spc_o,
  output logic               epoch_stb_o
);
  logic               wrap, last;
  logic [PHASE_W-1:0] resid, inc_used;
  logic [CNT_W-1:0]   cnt;
  chip_evt_t          evt_q;
  logic [PHASE_W-1:0] resid_q;
  logic [CNT_W-1:0]   spc_q;

  nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (sample_valid_i),
    .inc_i      (phase_inc_i),
    .wrap_o     (wrap),
    .resid_o    (resid),
    .inc_used_o (inc_used)
  );

  chip_sample_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (sample_valid_i),
    .wrap_i  (wrap),
    .cnt_o   (cnt)
  );

  chip_index_counter #(.CODE_LEN(CODE_LEN)) u_idx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wrap_i (wrap),
    .last_o (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q   <= '0;
      resid_q <= '0;
      spc_q   <= '0;
    end else begin
      evt_q.stb   <= wrap;
      evt_q.epoch <= last;
      if (wrap) begin
        resid_q <= resid;
        spc_q   <= cnt;
      end
    end
  end

  assign chip_stb_o  = evt_q.stb;
  assign epoch_stb_o = evt_q.epoch;
  assign residual_o  = resid_q;
  assign spc_o       = spc_q;
endmodule

// File: rtl/code_nco_chk.sv
module code_nco_chk #(
  parameter int unsigned PHASE_W = 32,
  parameter int unsigned CNT_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sample_valid_i,
  input logic               chip_stb_o,
  input logic [PHASE_W-1:0] residual_o,
  input logic [CNT_W-1:0]   spc_o,
  input logic               epoch_stb_o,
  input logic [PHASE_W-1:0] inc_used_i
);
  assert_no_stb_without_sample_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sample_valid_i) |-> !chip_stb_o);

  assert_resid_below_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_stb_o |-> residual_o < $past(inc_used_i));

  assert_count_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_stb_o |-> spc_o != '0);

  assert_epoch_with_chip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epoch_stb_o |-> chip_stb_o);

  assert_hold_between_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chip_stb_o |-> ($stable(residual_o) && $stable(spc_o)));
endmodule

bind code_nco code_nco_chk #(.PHASE_W(PHASE_W), .CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .chip_stb_o     (chip_stb_o),
  .residual_o     (residual_o),
  .spc_o          (spc_o),
  .epoch_stb_o    (epoch_stb_o),
  .inc_used_i     (inc_used)
);

// File: tb/sim_code_nco.sv
module sim_code_nco;
  localparam int CLK_P = 10;
  localparam int unsigned PW = 32;
  localparam int unsigned CL = 1023;
  localparam int unsigned CW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          vld = 1'b0;
  logic [PW-1:0] inc = '0;
  logic          stb, ep;
  logic [PW-1:0] res;
  logic [CW-1:0] spc;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // expectation model state
  logic [PW-1:0] m_acc, m_inc, m_res;
  bit            m_load, m_stb, m_ep, m_const, m_have_prev;
  int unsigned   m_cnt, m_idx, m_spc, epochs_exp, epochs_seen;
  logic [PW-1:0] prev_res, chip_inc;

  code_nco #(.PHASE_W(PW), .CODE_LEN(CL), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sample_valid_i(vld), .phase_inc_i(inc),
    .chip_stb_o(stb), .residual_o(res), .spc_o(spc), .epoch_stb_o(ep)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not end, actual cycles=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int unsigned thresh_cnt(input logic [PW-1:0] r, input logic [PW-1:0] i);
    longint unsigned full = 64'd1 << PW;
    longint unsigned fl = full / i;
    return (longint'(r) + fl * i < full) ? int'(fl + 1) : int'(fl);
  endfunction

  function automatic void model_reset();
    m_acc = '0; m_inc = '0; m_load = 1; m_cnt = 0; m_idx = 0;
    m_stb = 0; m_ep = 0; m_res = '0; m_spc = 0; m_have_prev = 0; m_const = 1;
    chip_inc = '0;
  endfunction

  // one sample: drive at negedge, predict, compare after posedge
  task automatic step(input bit v, input logic [PW-1:0] i);
    logic [PW:0]   sum;
    logic [PW-1:0] used;
    int unsigned   prior_spc;
    logic [PW-1:0] prior_res;
    bit            thr_ok;
    @(negedge clk);
    vld = v; inc = i;
    prior_spc = m_spc; prior_res = m_res;
    m_stb = 0; m_ep = 0; thr_ok = 0;
    if (v) begin
      used = m_load ? i : m_inc;
      if (m_cnt == 0 || m_load) chip_inc = used;
      else if (used != chip_inc) m_const = 0;
      sum = {1'b0, m_acc} + {1'b0, used};
      m_acc = sum[PW-1:0];
      if (sum[PW] || m_load) m_inc = i;
      m_load = 0;
      if (sum[PW]) begin
        thr_ok = m_const && m_have_prev;
        prev_res = m_res;
        m_stb = 1; m_res = sum[PW-1:0]; m_spc = m_cnt; m_cnt = 1;
        m_ep = (m_idx == CL - 1);
        m_idx = m_ep ? 0 : m_idx + 1;
        if (m_ep) epochs_exp++;
        m_have_prev = 1; m_const = 1; chip_inc = used;
      end else if (m_cnt != 32'hFFFF) m_cnt++;
    end
    @(posedge clk); #1;
    chk(stb == m_stb, "R3 chip strobe", stb, m_stb);
    if (m_stb) begin
      chk(res == m_res, "R4 residual", res, m_res);
      chk(spc == m_spc, "R5 sample count", spc, m_spc);
      chk(ep == m_ep, "R7 epoch strobe", ep, m_ep);
      if (thr_ok)
        chk(spc == thresh_cnt(prev_res, chip_inc), "R9 threshold count", spc,
            thresh_cnt(prev_res, chip_inc));
    end else begin
      chk(res == prior_res && spc == prior_spc, "R8 hold", res, prior_res);
      chk(!ep, "R7 no epoch without chip", ep, 0);
    end
    if (ep) epochs_seen++;
  endtask

  initial begin
    void'($urandom(32'd20161206));
    epochs_exp = 0; epochs_seen = 0;
    model_reset();
    repeat (3) @(negedge clk);
    chk(!stb && !ep && res == 0 && spc == 0, "R1 reset state", {stb, ep}, 0);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    chk(!stb && res == 0 && spc == 0, "R1 after release", res, 0);

    // ns = 4 exactly: first report 3, then 4, residual 0
    for (int k = 0; k < 12; k++) step(1, 32'h4000_0000);
    chk(spc == 4 && res == 0, "R5 ns=4 steady count", spc, 4);

    // R2: gaps in valid produce nothing
    for (int k = 0; k < 10; k++) step(0, 32'hFFFF_FFFF);

    // R6: change mid-chip, old word kept until wrap
    step(1, 32'h4000_0000);
    step(1, 32'h8000_0000);
    step(1, 32'h8000_0000);
    step(1, 32'h8000_0000);
    chk(stb == 1 && spc == 4, "R6 mid-chip change deferred", spc, 4);
    step(1, 32'h8000_0000);
    step(1, 32'h8000_0000);
    chk(stb == 1 && spc == 2, "R6 new word after wrap", spc, 2);

    // non-integer ratio ns=4.5, alternation with R9 check
    for (int k = 0; k < 60; k++) step(1, 32'd954437176);

    // random mix
    for (int k = 0; k < 20000; k++) begin
      logic [PW-1:0] ni;
      ni = 32'hFFFF_FFFF / ($urandom_range(20, 2));
      if ($urandom_range(15, 0) == 0) inc = ni;
      step($urandom_range(3, 0) != 0, ($urandom_range(15, 0) == 0) ? ni : inc);
    end

    // fast chips to reach several code epochs
    for (int k = 0; k < 6000; k++) step($urandom_range(7, 0) != 0, 32'hF000_0000);
    chk(epochs_seen == epochs_exp && epochs_exp > 0, "R7 epoch count", epochs_seen, epochs_exp);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule